// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Unit

This block is the combinational datapath behind a small CPU's prefixed instruction group. It takes one 8-bit operand, a 2-bit class field, a 3-bit selector and the four incoming condition flags, and returns the new operand value, a write-back enable and the new flags. The class field picks between a family of eight shifts and rotates, a single-bit test, a single-bit clear and a single-bit set. For the three bit classes the selector is the bit index; for the shift family it picks the operation.

The same unit also serves the short, unprefixed accumulator rotates. The decoder asserts `acc_mode` for those, and the unit then produces the same result and carry as the prefixed rotate while forcing the zero flag low. Operand fetch, register file access and write-back sequencing belong to the surrounding core. The bit that drives write-back is produced here so that the decoder needs no special case for the bit test.

Flags travel as a 4-bit vector: bit 3 is Z (zero), bit 2 is N (subtract), bit 1 is H (half carry) and bit 0 is C (carry).

Top module: `sru_unit`

## Requirements
- R1: With class 0, selector 0 rotates left so that bit 7 goes to both bit 0 and C. Selector 1 rotates right so that bit 0 goes to both bit 7 and C.
- R2: With class 0, selector 2 shifts left and fills bit 0 from the incoming C, loading C from old bit 7. Selector 3 shifts right and fills bit 7 from the incoming C, loading C from old bit 0.
- R3: With class 0, selector 4 shifts left with a zero fill. Selector 5 shifts right and keeps bit 7. Selector 7 shifts right with a zero fill. Each loads C from the bit shifted out.
- R4: With class 0, selector 6 exchanges the upper and lower nibbles and clears C.
- R5: Every class-0 operation clears N and H. When `acc_mode` is 0, every class-0 operation sets Z exactly when the result is zero.
- R6: With class 0, `acc_mode` 1 and selector 0 to 3, result and C match the `acc_mode` 0 case, and Z is 0.
- R7: Class 1 (bit test, index = selector) sets Z to the inverse of the operand bit, sets H, clears N, keeps C, and returns the operand unchanged on `result`.
- R8: Class 2 clears and class 3 sets the operand bit named by the selector. All four flags pass through unchanged.
- R9: `wr_en` is 1 for classes 0, 2 and 3 and 0 for class 1.
- R10: `acc_mode` has no effect on any output for classes 1 to 3 or for class 0 with selector 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | 0 shift/rotate, 1 bit test, 2 bit clear, 3 bit set |
| sel | input | 3 | Shift operation (class 0) or bit index (classes 1 to 3) |
| acc_mode | input | 1 | Accumulator-rotate form: forces Z low for class 0 selectors 0 to 3 |
| operand | input | 8 | Source value |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| result | output | 8 | New operand value |
| wr_en | output | 1 | Result should be written back |
| flags_out | output | 4 | Outgoing flags {Z,N,H,C} |

## Verification
The bench applies every operand value under every class, selector and accumulator-mode setting, each with the incoming carry both clear and set. The other incoming flag bits follow a pattern taken from the operand. Sweeping the carry separates the rotates that recirculate their own bit from those that pull in C, and shows that the bit test and the bit clear/set keep C. Operands 0x00, 0x01 and 0x80 tell apart a zero result produced by shifting out the last set bit from a zero operand. Running each accumulator-mode vector beside its prefixed twin shows that only Z differs, and only for the four rotates.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'd0,
        CLS_TEST  = 2'd1,
        CLS_CLEAR = 2'd2,
        CLS_SET   = 2'd3
    } sru_class_e;

    typedef enum logic [2:0] {
        SH_ROL_C  = 3'd0,
        SH_ROR_C  = 3'd1,
        SH_ROL_TC = 3'd2,
        SH_ROR_TC = 3'd3,
        SH_ASL    = 3'd4,
        SH_ASR    = 3'd5,
        SH_NIBX   = 3'd6,
        SH_LSR    = 3'd7
    } sru_shift_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } sru_flags_t;

endpackage

// File: rtl/sru_shift.sv
module sru_shift
    import sru_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [2:0]       sel,
    input  logic             acc_mode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output sru_flags_t       flags
);
    localparam int unsigned HALF = WIDTH / 2;
    localparam int unsigned MSB  = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic             cout;
    } shift_out_t;

    shift_out_t sh_d;
    logic       rot_form;

    always_comb begin
        sh_d = '{val: operand, cout: 1'b0};
        unique case (sru_shift_e'(sel))
            SH_ROL_C:  sh_d = '{val: {operand[MSB-1:0], operand[MSB]}, cout: operand[MSB]};
            SH_ROR_C:  sh_d = '{val: {operand[0], operand[MSB:1]},     cout: operand[0]};
            SH_ROL_TC: sh_d = '{val: {operand[MSB-1:0], carry_in},     cout: operand[MSB]};
            SH_ROR_TC: sh_d = '{val: {carry_in, operand[MSB:1]},       cout: operand[0]};
            SH_ASL:    sh_d = '{val: {operand[MSB-1:0], 1'b0},         cout: operand[MSB]};
            SH_ASR:    sh_d = '{val: {operand[MSB], operand[MSB:1]},   cout: operand[0]};
            SH_NIBX:   sh_d = '{val: {operand[HALF-1:0], operand[MSB:HALF]}, cout: 1'b0};
            SH_LSR:    sh_d = '{val: {1'b0, operand[MSB:1]},           cout: operand[0]};
            default:   sh_d = '{val: operand, cout: 1'b0};
        endcase
    end

    // Accumulator form only touches the four rotates.
    assign rot_form = acc_mode && (sel[2] == 1'b0);

    always_comb begin
        result  = sh_d.val;
        flags.z = (sh_d.val == '0) && !rot_form;
        flags.n = 1'b0;
        flags.h = 1'b0;
        flags.c = sh_d.cout;
    end

    // R4
    always_comb begin
        if (sel == SH_NIBX) begin
            nibx_carry_chk: assert (!flags.c && $countones(result) == $countones(operand))
                else $error("nibble exchange changed bit count or left carry set");
        end
    end

endmodule

// File: rtl/sru_bitop.sv
module sru_bitop
    import sru_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    localparam int unsigned IW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [IW-1:0]    idx,
    input  sru_class_e       op_class,
    input  sru_flags_t       flags_in,
    output logic [WIDTH-1:0] result,
    output sru_flags_t       flags
);
    logic [WIDTH-1:0] mask;

    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign mask[g] = (idx == IW'(g));
    end

    always_comb begin
        result = operand;
        flags  = flags_in;
        unique case (op_class)
            CLS_TEST: begin
                flags.z = ((operand & mask) == '0);
                flags.n = 1'b0;
                flags.h = 1'b1;
            end
            CLS_CLEAR: result = operand & ~mask;
            CLS_SET:   result = operand | mask;
            default:   result = operand;
        endcase
    end

    // R8
    always_comb begin
        if (op_class == CLS_CLEAR || op_class == CLS_SET) begin
            single_bit_edit_chk: assert ($countones(result ^ operand) <= 1)
                else $error("bit edit changed more than one bit");
        end
    end

endmodule

// File: rtl/sru_unit.sv
module sru_unit
    import sru_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    localparam int unsigned IW   = $clog2(WIDTH)
) (
    input  logic [1:0]       op_class,
    input  logic [2:0]       sel,
    input  logic             acc_mode,
    input  logic [WIDTH-1:0] operand,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic [3:0]       flags_out
);
    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             wr_en;
        sru_flags_t       flags;
    } unit_out_t;

    sru_flags_t       fin;
    logic [WIDTH-1:0] shift_res;
    sru_flags_t       shift_flg;
    logic [WIDTH-1:0] bit_res;
    sru_flags_t       bit_flg;
    unit_out_t        out_d;

    assign fin = sru_flags_t'(flags_in);

    sru_shift #(.WIDTH(WIDTH)) u_shift (
        .operand  (operand),
        .sel      (sel),
        .acc_mode (acc_mode),
        .carry_in (fin.c),
        .result   (shift_res),
        .flags    (shift_flg)
    );

    sru_bitop #(.WIDTH(WIDTH)) u_bitop (
        .operand  (operand),
        .idx      (sel[IW-1:0]),
        .op_class (sru_class_e'(op_class)),
        .flags_in (fin),
        .result   (bit_res),
        .flags    (bit_flg)
    );

    always_comb begin
        if (sru_class_e'(op_class) == CLS_SHIFT) begin
            out_d = '{result: shift_res, wr_en: 1'b1, flags: shift_flg};
        end else begin
            out_d = '{result: bit_res,
                      wr_en:  (sru_class_e'(op_class) != CLS_TEST),
                      flags:  bit_flg};
        end
    end

    assign result    = out_d.result;
    assign wr_en     = out_d.wr_en;
    assign flags_out = out_d.flags;

    always_comb begin
        // R5
        if (op_class == 2'd0) begin
            shift_nh_clear_chk: assert (flags_out[2:1] == 2'b00)
                else $error("shift left N or H set");
        end
        // R6
        if (op_class == 2'd0 && acc_mode && !sel[2]) begin
            acc_rot_zero_chk: assert (!flags_out[3])
                else $error("accumulator rotate set Z");
        end
        // R7
        if (op_class == 2'd1) begin
            test_no_write_chk: assert (!wr_en && result == operand && flags_out[0] == flags_in[0])
                else $error("bit test altered operand, carry or wrote back");
        end
        // R8
        if (op_class[1]) begin
            edit_flags_keep_chk: assert (flags_out == flags_in && wr_en)
                else $error("bit edit changed flags or dropped write-back");
        end
    end

endmodule

// File: tb/sru_unit_tb.sv
module sru_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_class = '0;
    logic [2:0] sel = '0;
    logic       acc_mode = 1'b0;
    logic [7:0] operand = '0;
    logic [3:0] flags_in = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags_out;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sru_unit u_dut (
        .op_class  (op_class),
        .sel       (sel),
        .acc_mode  (acc_mode),
        .operand   (operand),
        .flags_in  (flags_in),
        .result    (result),
        .wr_en     (wr_en),
        .flags_out (flags_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        for (int o = 0; o < 256; o++) begin
            for (int k = 0; k < 4; k++) begin
                for (int s = 0; s < 8; s++) begin
                    for (int a = 0; a < 2; a++) begin
                        for (int c = 0; c < 2; c++) begin
                            logic [7:0] op, er;
                            logic [3:0] fi, ef;
                            logic       ec, ew;
                            string      tag, ftag;
                            op = 8'(o);
                            fi = {op[5], op[6], op[7], 1'(c)};
                            @(posedge clk);
                            #2;
                            op_class = 2'(k); sel = 3'(s); acc_mode = 1'(a);
                            operand = op; flags_in = fi;
                            er = op; ef = fi; ew = 1'b1; ec = 1'b0;
                            if (k == 0) begin
                                case (s)
                                    0: begin er = (op << 1) | (op >> 7); ec = op[7]; tag = "R1"; end
                                    1: begin er = (op >> 1) | (op << 7); ec = op[0]; tag = "R1"; end
                                    2: begin er = (op << 1) | 8'(c);     ec = op[7]; tag = "R2"; end
                                    3: begin er = (op >> 1) | (8'(c) << 7); ec = op[0]; tag = "R2"; end
                                    4: begin er = op << 1;               ec = op[7]; tag = "R3"; end
                                    5: begin er = (op >> 1) | (op & 8'h80); ec = op[0]; tag = "R3"; end
                                    6: begin er = (op << 4) | (op >> 4); ec = 1'b0;  tag = "R4"; end
                                    default: begin er = op >> 1;         ec = op[0]; tag = "R3"; end
                                endcase
                                ef = {(er == 8'h00) && !(a == 1 && s < 4), 1'b0, 1'b0, ec};
                                ftag = (a == 1 && s < 4) ? "R6" : "R5";
                            end else if (k == 1) begin
                                ef = {((op >> s) & 8'h01) == 8'h00, 1'b0, 1'b1, 1'(c)};
                                ew = 1'b0; tag = "R7"; ftag = "R7";
                            end else begin
                                er = (k == 2) ? (op & ~(8'h01 << s)) : (op | (8'h01 << s));
                                tag = "R8"; ftag = "R8";
                            end
                            if (a == 1 && (k != 0 || s >= 4)) begin
                                tag = "R10"; ftag = "R10";
                            end
                            @(negedge clk);
                            vectors++;
                            if (result !== er) begin
                                fails++;
                                $display("FAIL %s result cls=%0d sel=%0d acc=%0d op=%02h cin=%0d: actual %02h expected %02h",
                                         tag, k, s, a, op, c, result, er);
                            end
                            if (flags_out !== ef) begin
                                fails++;
                                $display("FAIL %s flags cls=%0d sel=%0d acc=%0d op=%02h cin=%0d: actual %04b expected %04b",
                                         ftag, k, s, a, op, c, flags_out, ef);
                            end
                            if (wr_en !== ew) begin
                                fails++;
                                $display("FAIL R9 wr_en cls=%0d: actual %0b expected %0b", k, wr_en, ew);
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule